// File: doc/BRIEF.md
# Sine Staircase Level Generator

This block is the reference generator for a cascaded multilevel inverter that builds its output from ternary-weighted voltage steps. At each control tick it produces a signed level index: a magnitude from 0 to 242 and a sign. The index tracks one sine cycle of the selected line frequency. The switch-pattern encoder downstream turns each index into the on/off state of every power switch. A phase accumulator advances once per tick and walks the full period from 0 to 2π without a break. A quarter-wave table, mirrored over the four quadrants, supplies the sine magnitude. A fixed-point quantiser maps that magnitude onto 242 equal steps per half cycle, so one cycle passes through 485 distinct levels: 242 positive, 242 negative and zero.

The line frequency is chosen by one select input, either 50 Hz or 60 Hz. The phase step for each frequency is derived at elaboration from the clock rate and the tick divider. While the enable input is low, the output rests at level zero with positive sign. The phase and the tick timing restart from zero when enable returns high.

Top module: `sine_level_gen`

## Requirements
- R1: While reset (rst_n low) is applied and on the first cycle after it, level is 0, neg is 0 and valid is 0.
- R2: While en is high, valid is a one-cycle pulse exactly every TICK_DIV clock cycles, and the first pulse comes TICK_DIV cycles after en rises. Between pulses, level and neg hold their values.
- R3: The phase is PHASE_W bits wide and starts at 0. Each tick adds STEP(f) = (f·TICK_DIV·2^PHASE_W + CLK_HZ/2) / CLK_HZ (integer division) modulo 2^PHASE_W. A sample reports the phase value from before that tick's increment.
- R4: The top two phase bits select the quadrant and the next LUT_AW bits give the offset a, with N = 2^LUT_AW. Quadrants 0 and 2 use table index a; quadrants 1 and 3 use N−a. Table entry k is round((2^AMP_W−1)·sin(k·π/(2N))).
- R5: The magnitude is floor(242·s/(2^AMP_W−1)) for table sample s, so the full-scale sample gives exactly 242.
- R6: neg is 1 only in quadrants 2 and 3 (phase MSB set) and only when the magnitude is nonzero. Level zero is always reported with neg = 0.
- R7: fsel = 0 selects 50 Hz and fsel = 1 selects 60 Hz. A change of fsel takes effect on the next tick's increment and leaves the accumulated phase in place.
- R8: The cycle after en is seen low, level is 0, neg is 0 and valid is 0. The phase and the tick timing are cleared, so the first sample after re-enabling is taken at phase 0.
- R9: Over one full cycle the output reaches magnitude 242 with both signs and reaches level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low holds the output at level zero |
| fsel | input | 1 | Line frequency select: 0 = 50 Hz, 1 = 60 Hz |
| level | output | LVL_W (8) | Level magnitude, 0..242 |
| neg | output | 1 | Sign of the level, 1 = negative half cycle |
| valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench checks every sample of more than one full cycle at 50 Hz and at 60 Hz against an arithmetic model of phase, quadrant folding and quantisation. It therefore catches a table mirrored off by one entry, a peak that stops at 241, and a sign that lands on zero and creates a second zero level. It changes fsel in the middle of a cycle: a design that resets the phase on the change, or that applies the new step one tick late, produces a wrong magnitude on the following samples. It also drops and restores enable. A design that keeps stale phase or tick timing produces a first sample that is not at phase zero, or a first strobe that is not exactly TICK_DIV cycles after enable rises.

// File: rtl/sl_pkg.sv
package sl_pkg;

    typedef enum logic [1:0] {
        QD_RISE_POS = 2'd0,
        QD_FALL_POS = 2'd1,
        QD_RISE_NEG = 2'd2,
        QD_FALL_NEG = 2'd3
    } quadrant_e;

    // Rounded phase step per tick for a given line frequency.
    function automatic longint unsigned phase_step(
        input longint unsigned line_hz,
        input longint unsigned tick_div,
        input longint unsigned clk_hz,
        input int unsigned     phase_w
    );
        longint unsigned num;
        num = ((line_hz * tick_div) << phase_w) + (clk_hz / 2);
        return num / clk_hz;
    endfunction

endpackage

// File: rtl/sl_tick_gen.sv
module sl_tick_gen #(
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = en && (st_q.cnt == LAST);
        if (!en) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sl_phase_acc.sv
module sl_phase_acc #(
    parameter int unsigned PHASE_W  = 32,
    parameter longint unsigned CLK_HZ = 100_000_000,
    parameter int unsigned TICK_DIV = 1000,
    parameter int unsigned F_BASE   = 50,
    parameter int unsigned F_ALT    = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               fsel,
    output logic [PHASE_W-1:0] phase
);
    localparam longint unsigned STEP_BASE =
        sl_pkg::phase_step(F_BASE, TICK_DIV, CLK_HZ, PHASE_W);
    localparam longint unsigned STEP_ALT =
        sl_pkg::phase_step(F_ALT, TICK_DIV, CLK_HZ, PHASE_W);
    localparam logic [PHASE_W-1:0] INC_BASE = PHASE_W'(STEP_BASE);
    localparam logic [PHASE_W-1:0] INC_ALT  = PHASE_W'(STEP_ALT);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [PHASE_W-1:0] inc_sel;

    always_comb begin
        st_d    = st_q;
        inc_sel = fsel ? INC_ALT : INC_BASE;
        if (!en) begin
            st_d.acc = '0;
        end else if (tick) begin
            st_d.acc = st_q.acc + inc_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.acc;
endmodule

// File: rtl/sl_quarter_rom.sv
module sl_quarter_rom #(
    parameter int unsigned LUT_AW = 8,
    parameter int unsigned AMP_W  = 16
) (
    input  logic [LUT_AW:0]  idx,
    output logic [AMP_W-1:0] amp
);
    localparam int unsigned N_SEG   = 1 << LUT_AW;
    localparam real         AMP_MAX = real'((64'd1 << AMP_W) - 64'd1);
    localparam real         HALF_PI = 1.5707963267948966;

    logic [AMP_W-1:0] tbl [0:N_SEG];

    for (genvar k = 0; k <= N_SEG; k++) begin : g_ent
        localparam real ANG = HALF_PI * real'(k) / real'(N_SEG);
        localparam int unsigned VAL = $rtoi(AMP_MAX * $sin(ANG) + 0.5);
        assign tbl[k] = AMP_W'(VAL);
    end

    always_comb begin
        if (idx > (LUT_AW+1)'(N_SEG)) begin
            amp = '0;
        end else begin
            amp = tbl[idx];
        end
    end
endmodule

// File: rtl/sl_quantiser.sv
module sl_quantiser #(
    parameter int unsigned AMP_W  = 16,
    parameter int unsigned LEVELS = 242,
    parameter int unsigned LVL_W  = 8
) (
    input  logic [AMP_W-1:0] amp,
    input  logic             neg_half,
    output logic [LVL_W-1:0] level,
    output logic             neg
);
    localparam int unsigned PRW = AMP_W + LVL_W;
    localparam logic [PRW-1:0] SCALE   = PRW'(LEVELS);
    localparam logic [PRW-1:0] AMP_MAX = PRW'((64'd1 << AMP_W) - 64'd1);

    logic [PRW-1:0] prod;
    logic [PRW-1:0] quot;

    always_comb begin
        prod  = PRW'(amp) * SCALE;
        quot  = prod / AMP_MAX;
        level = LVL_W'(quot);
        neg   = neg_half && (level != '0);
    end
endmodule

// File: rtl/sine_level_gen.sv
module sine_level_gen #(
    parameter longint unsigned CLK_HZ = 100_000_000,
    parameter int unsigned TICK_DIV = 1000,
    parameter int unsigned PHASE_W  = 32,
    parameter int unsigned LUT_AW   = 8,
    parameter int unsigned AMP_W    = 16,
    parameter int unsigned LEVELS   = 242,
    parameter int unsigned F_BASE   = 50,
    parameter int unsigned F_ALT    = 60,
    localparam int unsigned LVL_W   = $clog2(LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fsel,
    output logic [LVL_W-1:0] level,
    output logic             neg,
    output logic             valid
);
    import sl_pkg::*;

    localparam logic [LUT_AW:0] N_SEG = (LUT_AW+1)'(1 << LUT_AW);

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             neg;
        logic             valid;
    } out_st_t;

    logic               tick;
    logic [PHASE_W-1:0] phase;
    quadrant_e          quad;
    logic [LUT_AW-1:0]  offs;
    logic [LUT_AW:0]    tbl_idx;
    logic [AMP_W-1:0]   amp;
    logic [LVL_W-1:0]   q_level;
    logic               q_neg;
    out_st_t            out_d, out_q;

    sl_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick)
    );

    sl_phase_acc #(
        .PHASE_W  (PHASE_W),
        .CLK_HZ   (CLK_HZ),
        .TICK_DIV (TICK_DIV),
        .F_BASE   (F_BASE),
        .F_ALT    (F_ALT)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick),
        .fsel  (fsel),
        .phase (phase)
    );

    // Quadrant fold: falling quadrants read the table backwards from the peak.
    always_comb begin
        quad = quadrant_e'(phase[PHASE_W-1 -: 2]);
        offs = phase[PHASE_W-3 -: LUT_AW];
        if (quad == QD_FALL_POS || quad == QD_FALL_NEG) begin
            tbl_idx = N_SEG - {1'b0, offs};
        end else begin
            tbl_idx = {1'b0, offs};
        end
    end

    sl_quarter_rom #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_rom (
        .idx (tbl_idx),
        .amp (amp)
    );

    sl_quantiser #(.AMP_W(AMP_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_quant (
        .amp      (amp),
        .neg_half (phase[PHASE_W-1]),
        .level    (q_level),
        .neg      (q_neg)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (!en) begin
            out_d = '0;
        end else if (tick) begin
            out_d.level = q_level;
            out_d.neg   = q_neg;
            out_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign level = out_q.level;
    assign neg   = out_q.neg;
    assign valid = out_q.valid;
endmodule

// File: rtl/sl_checker.sv
module sl_checker #(
    parameter int unsigned TICK_DIV = 1000,
    parameter int unsigned LEVELS   = 242,
    parameter int unsigned LVL_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [LVL_W-1:0] level,
    input logic             neg,
    input logic             valid
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (level == '0 && !neg && !valid));

    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(LEVELS));

    p_zero_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !neg);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (level == '0 && !neg && !valid));

    p_valid_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(en));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !valid) |-> ($stable(level) && $stable(neg)));

    if (TICK_DIV > 1) begin : g_pulse
        p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
            valid |=> !valid);
    end
endmodule

bind sine_level_gen sl_checker #(
    .TICK_DIV (TICK_DIV),
    .LEVELS   (LEVELS),
    .LVL_W    (LVL_W)
) u_sl_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .level (level),
    .neg   (neg),
    .valid (valid)
);

// File: tb/tb_sine_level_gen.sv
module tb_sine_level_gen;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned P_CLK_HZ = 1_000_000;
    localparam int unsigned P_DIV = 4;
    localparam int unsigned P_PW  = 24;
    localparam int unsigned P_LAW = 6;
    localparam int unsigned P_AW  = 12;
    localparam int unsigned P_LEV = 242;
    localparam int unsigned P_LW  = 8;
    localparam longint unsigned N_SEG = 64'd1 << P_LAW;
    localparam longint unsigned AMAX  = (64'd1 << P_AW) - 1;
    localparam longint unsigned PMASK = (64'd1 << P_PW) - 1;

    logic clk, rst_n, en, fsel;
    logic [P_LW-1:0] level;
    logic neg, valid;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    sine_level_gen #(
        .CLK_HZ (P_CLK_HZ), .TICK_DIV (P_DIV), .PHASE_W (P_PW),
        .LUT_AW (P_LAW), .AMP_W (P_AW), .LEVELS (P_LEV),
        .F_BASE (50), .F_ALT (60)
    ) dut (
        .clk (clk), .rst_n (rst_n), .en (en), .fsel (fsel),
        .level (level), .neg (neg), .valid (valid)
    );

    initial clk = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic longint unsigned step_of(input bit fs);
        longint unsigned f;
        f = fs ? 60 : 50;
        return (((f * P_DIV) << P_PW) + P_CLK_HZ / 2) / P_CLK_HZ;
    endfunction

    function automatic int exp_mag(input longint unsigned ph);
        longint unsigned q, a, idx, s;
        q = (ph >> (P_PW - 2)) & 3;
        a = (ph >> (P_PW - 2 - P_LAW)) & (N_SEG - 1);
        idx = q[0] ? (N_SEG - a) : a;
        s = longint'($rtoi(real'(AMAX) * $sin(1.5707963267948966 * real'(idx) / real'(N_SEG)) + 0.5));
        return int'((s * P_LEV) / AMAX);
    endfunction

    // Reference model, evaluated away from the active edge.
    longint unsigned mph = 0;
    bit l_en = 0, l_fs = 0, l_rst = 0;
    bit first_in_run = 1;
    int gap = 0;
    int max_pos = 0, max_neg = 0;
    bit saw_zero = 0;
    logic [P_LW-1:0] prev_level = '0;
    logic prev_neg = 0;

    always @(negedge clk) begin
        if (!l_rst || !l_en) begin
            if (l_rst) begin
                chk(level == 0 && !neg && !valid, "R8 idle output", level, 0);
            end
            mph = 0;
            gap = 0;
            first_in_run = 1;
        end else begin
            gap++;
            if (valid) begin
                int em;
                bit en_neg;
                em = exp_mag(mph);
                en_neg = mph[P_PW-1] && em != 0;
                chk(gap == P_DIV, "R2 tick spacing", gap, P_DIV);
                if (first_in_run)
                    chk(level == 0 && !neg, "R8 restart at phase 0", level, 0);
                chk(int'(level) == em, l_fs ? "R7 R4 R5 magnitude 60Hz" : "R3 R4 R5 magnitude 50Hz",
                    level, em);
                chk(neg == en_neg, "R6 sign", neg, en_neg);
                if (!neg && int'(level) > max_pos) max_pos = int'(level);
                if (neg && int'(level) > max_neg) max_neg = int'(level);
                if (level == 0) saw_zero = 1;
                mph = (mph + step_of(l_fs)) & PMASK;
                first_in_run = 0;
                gap = 0;
            end else begin
                chk(level == prev_level && neg == prev_neg, "R2 hold between strobes",
                    level, prev_level);
            end
        end
        prev_level = level;
        prev_neg = neg;
        l_en = en;
        l_fs = fsel;
        l_rst = rst_n;
    end

    initial begin
        rst_n = 0; en = 1; fsel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(level == 0 && !neg && !valid, "R1 reset state", level, 0);
        @(posedge clk); #1;
        rst_n = 1; en = 0;
        @(negedge clk);
        chk(level == 0 && !neg && !valid, "R1 after reset", level, 0);
        @(posedge clk); #1;
        en = 1; fsel = 0;
        repeat (20400) @(posedge clk);
        #1 fsel = 1;
        repeat (3001) @(posedge clk);
        #1 en = 0;
        repeat (20) @(posedge clk);
        #1 en = 1; fsel = 1;
        repeat (16900) @(posedge clk);
        #1 fsel = 0;
        repeat (400) @(posedge clk);
        @(negedge clk);
        chk(max_pos == P_LEV, "R9 positive peak", max_pos, P_LEV);
        chk(max_neg == P_LEV, "R9 negative peak", max_neg, P_LEV);
        chk(saw_zero, "R9 zero level reached", saw_zero, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule